// File: doc/BRIEF.md
# External Bus Data Alignment Sequencer

This block connects an internal bus master to a 16-bit external data bus serving ROM and SRAM. The master issues one read or write request at a time, of byte, word or longword size, together with the width of the addressed area: either a narrow area, where only one byte moves per external cycle, or a wide area, where a byte or a word moves per external cycle. The sequencer splits each request into as many external cycles as that width requires. For each cycle it drives the address, the write enable, the upper and lower byte strobes and the write data on the correct half of the bus. It then reassembles the read data into a right-justified 32-bit result.

Byte order is big-endian: the most significant byte or word of a request sits at the lowest address and moves in the first external cycle. Every external cycle lasts exactly one clock. Wait states, chip selects and area configuration are handled elsewhere, and the area width arrives as a plain input with each request. When a request cannot be carried out, the block reports an error and performs no bus cycle. This applies to a word or longword at an odd address in a wide area, and to the reserved size code.

Top module: `ext_bus_align_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the clock that follows, and it stays low until the completion clock has passed.
- R2: In a narrow area (`req_area16`=0), every external cycle asserts `bus_ub`=1 and `bus_lb`=0. Write data is placed on bits 15:8 with bits 7:0 driven to zero. On reads, bits 7:0 of `bus_rdata` are ignored.
- R3: In a narrow area, a byte request (`req_size`=00) takes 1 external cycle, a word (01) takes 2 and a longword (10) takes 4. The cycles run in consecutive clocks, and the address starts at `req_addr` and rises by 1 each cycle. Odd start addresses are allowed.
- R4: In a wide area (`req_area16`=1), a word takes 1 external cycle with both strobes high. A longword takes 2 cycles with both strobes high, at `req_addr` and `req_addr`+2.
- R5: In a wide area, a byte request takes 1 cycle. At an even address it asserts only `bus_ub` and uses bits 15:8. At an odd address it asserts only `bus_lb` and uses bits 7:0. The unused half of the write data is driven to zero.
- R6: Write data is big-endian: the first cycle carries the most significant byte or word of the request's data. A byte request uses `req_wdata[7:0]` and a word request uses `req_wdata[15:0]`.
- R7: Read data is assembled big-endian and right-justified in `rsp_rdata`. The byte or word from the first cycle is the most significant, and bits above the request size are zero.
- R8: `rsp_done` is a one-clock pulse in the clock right after the last external cycle. It comes with `rsp_err`=0, and `rsp_rdata` is valid during that same clock.
- R9: A word or longword at an odd address in a wide area, or `req_size`=11, produces no external cycle. In the clock right after acceptance it gives `rsp_done`=1 and `rsp_err`=1.
- R10: Outside external cycles (`bus_cyc`=0), `bus_ub`, `bus_lb` and `bus_we` are low and `bus_wdata` is zero. After reset, `req_ready`=1, `rsp_done`=0 and `bus_cyc`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| req_area16 | input | 1 | 1 = wide (16-bit) area, 0 = narrow (8-bit) area |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 4*LANE_W | Write data, right-justified |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Request rejected, valid with rsp_done |
| rsp_rdata | output | 4*LANE_W | Assembled read data, valid with rsp_done |
| bus_cyc | output | 1 | External cycle active this clock |
| bus_addr | output | ADDR_W | External address |
| bus_we | output | 1 | External write enable |
| bus_ub | output | 1 | Upper byte strobe (bits 15:8) |
| bus_lb | output | 1 | Lower byte strobe (bits 7:0) |
| bus_wdata | output | 2*LANE_W | External write data |
| bus_rdata | input | 2*LANE_W | External read data, sampled at the end of each read cycle |

## Verification
The first external cycle of an accepted request is due in the clock after the accepting edge. The remaining cycles follow back to back, and the completion pulse comes one clock after the last of them. A request of N cycles therefore completes N+1 clocks after acceptance, and a rejected one completes after exactly 1. The driver counts falling edges from acceptance to `rsp_done` and compares the count with the N it derives from size, area and address. It also checks `req_ready` in the first busy clock and in the clock after completion. A monitor samples every falling edge and pops one expected bus cycle per clock with `bus_cyc` high, and one expected response per `rsp_done`. Each result is compared in exactly the clock it is due.

// File: rtl/ebas_pkg.sv
package ebas_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_e;

   // how one request is cut into external cycles
   typedef struct packed {
      logic [2:0] ncyc;   // number of external cycles
      logic       wide;   // each cycle moves a full word
      logic       bad;    // request rejected
   } split_plan_t;

endpackage

// File: rtl/ebas_split_plan.sv
module ebas_split_plan
   import ebas_pkg::*;
(
   input  acc_size_e   size,
   input  logic        area16,
   input  logic        addr_lsb,
   output split_plan_t plan
);

   always_comb begin
      plan = '0;
      case (size)
         SZ_BYTE: plan.ncyc = 3'd1;
         SZ_WORD: begin
            if (area16) begin
               plan.wide = 1'b1;
               plan.ncyc = 3'd1;
               plan.bad  = addr_lsb;
            end else begin
               plan.ncyc = 3'd2;
            end
         end
         SZ_LONG: begin
            if (area16) begin
               plan.wide = 1'b1;
               plan.ncyc = 3'd2;
               plan.bad  = addr_lsb;
            end else begin
               plan.ncyc = 3'd4;
            end
         end
         default: plan.bad = 1'b1;
      endcase
      if (plan.bad) begin
         plan.ncyc = 3'd0;
      end
   end

endmodule

// File: rtl/ebas_lane_drive.sv
module ebas_lane_drive #(
   parameter int LANE_W    = 8,
   parameter int INT_LANES = 4
) (
   input  logic [INT_LANES*LANE_W-1:0] wdata,
   input  logic [2:0]                  nbytes,
   input  logic [1:0]                  idx,
   input  logic                        wide,
   input  logic                        area16,
   input  logic                        addr_lsb,
   input  logic                        active,
   output logic [2*LANE_W-1:0]         lane_wdata,
   output logic                        ub,
   output logic                        lb
);

   localparam int BI_W = $clog2(INT_LANES);

   logic [LANE_W-1:0] lanes [INT_LANES];

   for (genvar gi = 0; gi < INT_LANES; gi++) begin : g_lane_split
      assign lanes[gi] = wdata[gi*LANE_W +: LANE_W];
   end

   logic [BI_W-1:0] bsel;
   logic [BI_W-2:0] wsel;

   always_comb begin
      // most significant part leaves first
      bsel = BI_W'(nbytes - 3'd1 - {1'b0, idx});
      wsel = (BI_W-1)'((nbytes >> 1) - 3'd1 - {1'b0, idx});
   end

   always_comb begin
      lane_wdata = '0;
      ub         = 1'b0;
      lb         = 1'b0;
      if (active) begin
         if (wide) begin
            lane_wdata = {lanes[{wsel, 1'b1}], lanes[{wsel, 1'b0}]};
            ub         = 1'b1;
            lb         = 1'b1;
         end else if (area16 && addr_lsb) begin
            lane_wdata = {{LANE_W{1'b0}}, lanes[bsel]};
            lb         = 1'b1;
         end else begin
            lane_wdata = {lanes[bsel], {LANE_W{1'b0}}};
            ub         = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ebas_read_pack.sv
module ebas_read_pack #(
   parameter int LANE_W    = 8,
   parameter int INT_LANES = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        capture,
   input  logic                        wide,
   input  logic                        low_lane,
   input  logic [2*LANE_W-1:0]         lane_rdata,
   output logic [INT_LANES*LANE_W-1:0] packed_q
);

   localparam int INT_W = INT_LANES * LANE_W;

   logic [LANE_W-1:0] pick;

   assign pick = low_lane ? lane_rdata[LANE_W-1:0] : lane_rdata[2*LANE_W-1:LANE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         packed_q <= '0;
      end else if (clear) begin
         packed_q <= '0;
      end else if (capture) begin
         if (wide) begin
            packed_q <= {packed_q[INT_W-2*LANE_W-1:0], lane_rdata};
         end else begin
            packed_q <= {packed_q[INT_W-LANE_W-1:0], pick};
         end
      end
   end

endmodule

// File: rtl/ext_bus_align_seq.sv
module ext_bus_align_seq
   import ebas_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int LANE_W    = 8,
   parameter int INT_LANES = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_write,
   input  logic [1:0]                  req_size,
   input  logic                        req_area16,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [INT_LANES*LANE_W-1:0] req_wdata,
   output logic                        rsp_done,
   output logic                        rsp_err,
   output logic [INT_LANES*LANE_W-1:0] rsp_rdata,
   output logic                        bus_cyc,
   output logic [ADDR_W-1:0]           bus_addr,
   output logic                        bus_we,
   output logic                        bus_ub,
   output logic                        bus_lb,
   output logic [2*LANE_W-1:0]         bus_wdata,
   input  logic [2*LANE_W-1:0]         bus_rdata
);

   localparam int EXT_W = 2 * LANE_W;
   localparam int INT_W = INT_LANES * LANE_W;

   if (INT_LANES != 4) begin : g_chk_lanes
      $error("ext_bus_align_seq: INT_LANES must be 4");
   end
   if (ADDR_W < 2) begin : g_chk_addr
      $error("ext_bus_align_seq: ADDR_W must be at least 2");
   end
   if (LANE_W < 1) begin : g_chk_lane_w
      $error("ext_bus_align_seq: LANE_W must be positive");
   end

   seq_state_e        state_q;
   acc_size_e         size_q;
   logic              area16_q;
   logic              we_q;
   logic [INT_W-1:0]  wdata_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        idx_q;
   logic [2:0]        ncyc_q;
   logic              wide_q;
   logic              err_q;

   split_plan_t plan;
   logic        accept;
   logic        last_cyc;
   logic [EXT_W-1:0] lane_wdata;
   logic        lane_ub;
   logic        lane_lb;
   logic [INT_W-1:0] packed_q;

   ebas_split_plan i_plan (
      .size     (acc_size_e'(req_size)),
      .area16   (req_area16),
      .addr_lsb (req_addr[0]),
      .plan     (plan)
   );

   assign accept   = req_valid && req_ready;
   assign last_cyc = ({1'b0, idx_q} == (ncyc_q - 3'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         size_q   <= SZ_BYTE;
         area16_q <= 1'b0;
         we_q     <= 1'b0;
         wdata_q  <= '0;
         addr_q   <= '0;
         idx_q    <= '0;
         ncyc_q   <= '0;
         wide_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  size_q   <= acc_size_e'(req_size);
                  area16_q <= req_area16;
                  we_q     <= req_write;
                  wdata_q  <= req_wdata;
                  addr_q   <= req_addr;
                  idx_q    <= '0;
                  ncyc_q   <= plan.ncyc;
                  wide_q   <= plan.wide;
                  err_q    <= plan.bad;
                  state_q  <= plan.bad ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               idx_q  <= idx_q + 2'd1;
               addr_q <= addr_q + {{(ADDR_W-2){1'b0}}, wide_q, !wide_q};
               if (last_cyc) begin
                  state_q <= ST_FIN;
               end
            end
            ST_FIN: begin
               state_q <= ST_IDLE;
               err_q   <= 1'b0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign bus_cyc   = (state_q == ST_RUN);
   assign bus_addr  = addr_q;
   assign bus_we    = bus_cyc && we_q;
   assign bus_ub    = lane_ub;
   assign bus_lb    = lane_lb;
   assign bus_wdata = we_q ? lane_wdata : '0;

   ebas_lane_drive #(
      .LANE_W    (LANE_W),
      .INT_LANES (INT_LANES)
   ) i_lanes (
      .wdata      (wdata_q),
      .nbytes     (3'd1 << size_q),
      .idx        (idx_q),
      .wide       (wide_q),
      .area16     (area16_q),
      .addr_lsb   (addr_q[0]),
      .active     (bus_cyc),
      .lane_wdata (lane_wdata),
      .ub         (lane_ub),
      .lb         (lane_lb)
   );

   ebas_read_pack #(
      .LANE_W    (LANE_W),
      .INT_LANES (INT_LANES)
   ) i_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .capture    (bus_cyc && !we_q),
      .wide       (wide_q),
      .low_lane   (area16_q && addr_q[0]),
      .lane_rdata (bus_rdata),
      .packed_q   (packed_q)
   );

   assign rsp_done  = (state_q == ST_FIN);
   assign rsp_err   = rsp_done && err_q;
   assign rsp_rdata = packed_q;

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_cyc && !rsp_done)); // R1
   AST_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !plan.bad) |=> (bus_cyc && !req_ready)); // R1
   AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !area16_q) |-> (bus_ub && !bus_lb && bus_wdata[LANE_W-1:0] == '0)); // R2
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && $past(bus_cyc)) |-> (bus_addr == $past(bus_addr) + (wide_q ? ADDR_W'(2) : ADDR_W'(1)))); // R3
   AST_WIDE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && wide_q) |-> (bus_ub && bus_lb)); // R4
   AST_BYTE_LANE16: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && area16_q && !wide_q) |-> (bus_ub == !bus_addr[0] && bus_lb == bus_addr[0])); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R8
   AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> !$past(bus_cyc)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cyc |-> (!bus_ub && !bus_lb && !bus_we && bus_wdata == '0)); // R10

endmodule

// File: tb/test_ext_bus_align_seq.sv
module test_ext_bus_align_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic        req_area16 = 1'b0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_done;
   logic        rsp_err;
   logic [31:0] rsp_rdata;
   logic        bus_cyc;
   logic [15:0] bus_addr;
   logic        bus_we;
   logic        bus_ub;
   logic        bus_lb;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;

   always #5 clk = ~clk;

   ext_bus_align_seq i_ext_bus_align_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_size   (req_size),
      .req_area16 (req_area16),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .rsp_done   (rsp_done),
      .rsp_err    (rsp_err),
      .rsp_rdata  (rsp_rdata),
      .bus_cyc    (bus_cyc),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_ub     (bus_ub),
      .bus_lb     (bus_lb),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;

   // external memory model, one byte per address
   logic [7:0] mem [256];
   logic       cur_a16 = 1'b0;

   // narrow area: lower half carries junk that must be ignored (R2)
   assign bus_rdata = cur_a16 ? {mem[{bus_addr[7:1], 1'b0}], mem[{bus_addr[7:1], 1'b1}]}
                              : {mem[bus_addr[7:0]], 8'hEE};

   typedef struct {
      logic [15:0] a;
      bit          we;
      bit          ub;
      bit          lb;
      logic [15:0] wd;
      string       tag;
   } cyc_t;

   typedef struct {
      bit          err;
      bit          chk_data;
      logic [31:0] rd;
      string       tag;
   } rsp_t;

   cyc_t cyc_q[$];
   rsp_t rsp_q[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
      end
   endtask

   // monitor: compares the design's outputs with the expected items
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_cyc) begin
            if (cyc_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected bus cycle addr", {16'h0, bus_addr}, 32'h0);
            end else begin
               cyc_t e;
               e = cyc_q.pop_front();
               chk(bus_addr == e.a, e.tag, "bus_addr", {16'h0, bus_addr}, {16'h0, e.a});
               chk(bus_we == e.we, e.tag, "bus_we", {31'h0, bus_we}, {31'h0, e.we});
               chk({bus_ub, bus_lb} == {e.ub, e.lb}, e.tag, "strobes ub,lb",
                   {30'h0, bus_ub, bus_lb}, {30'h0, e.ub, e.lb});
               if (e.we) begin
                  chk(bus_wdata == e.wd, e.tag, "bus_wdata", {16'h0, bus_wdata}, {16'h0, e.wd});
               end
            end
            if (bus_we) begin
               if (!cur_a16) begin
                  mem[bus_addr[7:0]] = bus_wdata[15:8];
               end else begin
                  if (bus_ub) mem[{bus_addr[7:1], 1'b0}] = bus_wdata[15:8];
                  if (bus_lb) mem[{bus_addr[7:1], 1'b1}] = bus_wdata[7:0];
               end
            end
         end else begin
            if (bus_ub || bus_lb || bus_we || bus_wdata != 16'h0) begin
               chk(1'b0, "R10", "idle bus activity ub,lb,we,wdata",
                   {13'h0, bus_ub, bus_lb, bus_we, bus_wdata}, 32'h0);
            end
         end
         if (rsp_done) begin
            if (rsp_q.size() == 0) begin
               chk(1'b0, "R8", "unexpected rsp_done", 32'h1, 32'h0);
            end else begin
               rsp_t r;
               r = rsp_q.pop_front();
               chk(rsp_err == r.err, r.tag, "rsp_err", {31'h0, rsp_err}, {31'h0, r.err});
               if (r.chk_data) begin
                  chk(rsp_rdata == r.rd, r.tag, "rsp_rdata", rsp_rdata, r.rd);
               end
            end
         end
      end
   end

   // driver: pushes the expected cycles and response, then runs the request
   task automatic do_req(input bit we, input logic [1:0] sz, input bit a16,
                         input logic [15:0] addr, input logic [31:0] wd, input string tag);
      int   nb;
      int   ncyc;
      bit   bad;
      logic [31:0] exp_rd;
      int   lat;
      nb   = 1 << sz;
      bad  = (sz == 2'd3) || (a16 && sz != 2'd0 && addr[0]);
      ncyc = 0;
      if (!bad) begin
         if (!a16) begin
            for (int k = 0; k < nb; k++) begin
               cyc_t c;
               c.a = addr + 16'(k); c.we = we; c.ub = 1'b1; c.lb = 1'b0;
               c.wd = {8'(wd >> (8 * (nb - 1 - k))), 8'h00};
               c.tag = tag;
               cyc_q.push_back(c);
               ncyc++;
            end
         end else if (sz == 2'd0) begin
            cyc_t c;
            c.a = addr; c.we = we; c.ub = !addr[0]; c.lb = addr[0];
            c.wd = addr[0] ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00};
            c.tag = tag;
            cyc_q.push_back(c);
            ncyc = 1;
         end else begin
            for (int k = 0; k < nb / 2; k++) begin
               cyc_t c;
               c.a = addr + 16'(2 * k); c.we = we; c.ub = 1'b1; c.lb = 1'b1;
               c.wd = 16'(wd >> (16 * (nb / 2 - 1 - k)));
               c.tag = tag;
               cyc_q.push_back(c);
               ncyc++;
            end
         end
      end
      exp_rd = '0;
      if (!bad && !we) begin
         for (int k = 0; k < nb; k++) begin
            exp_rd = (exp_rd << 8) | {24'h0, mem[8'(addr + 16'(k))]};
         end
      end
      begin
         rsp_t r;
         r.err = bad; r.chk_data = !bad && !we; r.rd = exp_rd; r.tag = tag;
         rsp_q.push_back(r);
      end

      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "req_ready before request", {31'h0, req_ready}, 32'h1);
      req_valid  = 1'b1;
      req_write  = we;
      req_size   = sz;
      req_area16 = a16;
      cur_a16    = a16;
      req_addr   = addr;
      req_wdata  = wd;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      chk(req_ready == 1'b0, "R1", "req_ready while busy", {31'h0, req_ready}, 32'h0);
      while (!rsp_done && lat < 12) begin
         @(negedge clk);
         lat++;
      end
      // R8 completion latency, R9 rejected in one clock
      chk(lat == ncyc + 1, bad ? "R9" : "R8", "clocks to rsp_done", 32'(lat), 32'(ncyc + 1));
      @(negedge clk);
      chk(rsp_done == 1'b0, "R8", "rsp_done is one pulse", {31'h0, rsp_done}, 32'h0);
      chk(req_ready == 1'b1, "R1", "req_ready after completion", {31'h0, req_ready}, 32'h1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1, "R10", "req_ready in reset", {31'h0, req_ready}, 32'h1);
      chk(rsp_done == 1'b0, "R10", "rsp_done in reset", {31'h0, rsp_done}, 32'h0);
      chk(bus_cyc == 1'b0, "R10", "bus_cyc in reset", {31'h0, bus_cyc}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // narrow area
      do_req(1'b1, 2'd2, 1'b0, 16'h0010, 32'hA1B2C3D4, "R2 R3 R6 longword write narrow");
      do_req(1'b0, 2'd2, 1'b0, 16'h0010, 32'h0,        "R2 R7 longword read narrow");
      do_req(1'b1, 2'd1, 1'b0, 16'h0021, 32'hFFFF5566, "R3 R6 word write narrow odd");
      do_req(1'b0, 2'd1, 1'b0, 16'h0021, 32'h0,        "R3 R7 word read narrow odd");
      do_req(1'b1, 2'd0, 1'b0, 16'h0033, 32'h1234569C, "R2 R6 byte write narrow");
      do_req(1'b0, 2'd0, 1'b0, 16'h0033, 32'h0,        "R2 R7 byte read narrow");

      // wide area
      do_req(1'b1, 2'd2, 1'b1, 16'h0040, 32'h11223344, "R4 R6 longword write wide");
      do_req(1'b0, 2'd2, 1'b1, 16'h0040, 32'h0,        "R4 R7 longword read wide");
      do_req(1'b1, 2'd1, 1'b1, 16'h0050, 32'h0000BEEF, "R4 R6 word write wide");
      do_req(1'b0, 2'd1, 1'b1, 16'h0050, 32'h0,        "R4 R7 word read wide");
      do_req(1'b1, 2'd0, 1'b1, 16'h0060, 32'h0000007A, "R5 byte write wide even");
      do_req(1'b1, 2'd0, 1'b1, 16'h0061, 32'h0000008B, "R5 byte write wide odd");
      do_req(1'b0, 2'd0, 1'b1, 16'h0060, 32'h0,        "R5 R7 byte read wide even");
      do_req(1'b0, 2'd0, 1'b1, 16'h0061, 32'h0,        "R5 R7 byte read wide odd");
      do_req(1'b0, 2'd1, 1'b1, 16'h0060, 32'h0,        "R5 R7 word read over byte lanes");

      // cross-width readback
      do_req(1'b0, 2'd2, 1'b0, 16'h0040, 32'h0,        "R3 R7 narrow read of wide data");

      // rejected requests
      do_req(1'b1, 2'd1, 1'b1, 16'h0051, 32'h0000DEAD, "R9 odd word wide");
      do_req(1'b0, 2'd2, 1'b1, 16'h0043, 32'h0,        "R9 odd longword wide");
      do_req(1'b0, 2'd3, 1'b0, 16'h0010, 32'h0,        "R9 reserved size");
      do_req(1'b0, 2'd2, 1'b0, 16'h0010, 32'h0,        "R9 memory untouched after reject");

      repeat (3) @(negedge clk);
      chk(cyc_q.size() == 0, "R3", "bus cycles left over", 32'(cyc_q.size()), 32'h0);
      chk(rsp_q.size() == 0, "R8", "responses left over", 32'(rsp_q.size()), 32'h0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule